// File: doc/BRIEF.md
# Burst Data Target for a Shared Address/Data Bus

This block is the responding side of a synchronous bus on which address and data share one set of lines. An initiator opens a transaction by pulling an active-low cycle line low. On the following clock it places the start address on the shared lines and a 4-bit command on a separate command bus. After that the transfer runs as a burst of any length. Every bus input is sampled on the rising clock edge.

The target claims reads and writes whose start address falls inside a window set by parameters. It moves each data beat through a simple local memory port, and inserts wait states for as long as that port reports not-ready. A beat completes only on an edge where both the initiator's ready and the target's ready are low. The initiator releases the cycle line to announce that one more beat is to come. For reads, the target leaves the shared lines undriven for one dead cycle before it drives data. After the last beat it keeps driving its ready line high for one more cycle and then releases it.

Top module: `burst_target`

## Requirements
- R1: While reset is applied and right after it, `tgt_rdy_oe`, `bus_oe` and `mem_req` are 0 and `tgt_rdy_n` is 1.
- R2: A transaction starts at an edge where `cyc_n` is sampled low after it was sampled high at the previous edge. The address and command are taken from `bus_in` and `bus_cmd` at the next edge, not at the start edge.
- R3: Only command 4'b0110 (read) and 4'b0111 (write) are claimed. With any other command the target never drives `tgt_rdy_oe` or `bus_oe`, and it never raises `mem_req`.
- R4: A transaction is claimed only when BASE <= start address < BASE+SIZE. Outside that range the target stays undriven.
- R5: For a read, the cycle after the address cycle is a dead cycle: `tgt_rdy_oe`=1, `tgt_rdy_n`=1, `bus_oe`=0. `bus_oe` rises in the cycle after that. For a write, data cycles follow the address cycle directly.
- R6: In a data cycle `mem_req` equals the inverse of `mst_rdy_n`. `tgt_rdy_n` is low exactly when `mem_req` and `mem_ready` are both high. A beat completes on an edge where `mst_rdy_n` and `tgt_rdy_n` are both low.
- R7: `mem_addr` is the word index (start address − BASE)/4. It advances by one after every beat and wraps within the window.
- R8: On a write data cycle, `mem_we`=1 and `mem_wdata` equals `bus_in`.
- R9: On a read data cycle, `mem_we`=0, `bus_oe`=1 and `bus_out` equals `mem_rdata`.
- R10: A beat completed with `cyc_n` high is the last one. In the following cycle `tgt_rdy_oe`=1, `tgt_rdy_n`=1 and `bus_oe`=0. In the cycle after that, `tgt_rdy_oe` is 0.
- R11: If `cyc_n` falls during the release cycle of R10, a new transaction starts with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_n | input | 1 | Transaction-in-progress line from initiator, active low |
| mst_rdy_n | input | 1 | Initiator ready, active low |
| bus_cmd | input | 4 | Command during the address cycle |
| bus_in | input | 32 | Value present on the shared lines |
| bus_out | output | 32 | Read data the target drives |
| bus_oe | output | 1 | Target drives the shared lines |
| tgt_rdy_n | output | 1 | Target ready, active low |
| tgt_rdy_oe | output | 1 | Target drives its ready line |
| mem_req | output | 1 | Local port access request |
| mem_we | output | 1 | Local port write strobe qualifier |
| mem_addr | output | LW | Local word index |
| mem_wdata | output | 32 | Local write data |
| mem_rdata | input | 32 | Local read data, valid when ready |
| mem_ready | input | 1 | Local port can complete this cycle |

## Verification
The bench goes after the wait-state interplay, where both ready lines toggle pseudo-randomly. A target that took a beat on one ready alone would either skip memory words or write the same word twice. It starts bursts near the top of the window, where an address counter that ran past its width would touch the wrong word. It issues reads right after an address cycle, and a target without the dead cycle would raise `bus_oe` one cycle early. It also issues commands and addresses outside the claimed set, which a loose decoder would answer. Back-to-back transactions with no idle cycle expose a target that ignores a cycle-line fall during its release cycle.

// File: rtl/burst_target.sv
module burst_target #(
  parameter logic [31:0] BASE = 32'h0000_1000,
  parameter int          SIZE = 64,
  localparam int         LW   = $clog2(SIZE / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_n,
  input  logic          mst_rdy_n,
  input  logic [3:0]    bus_cmd,
  input  logic [31:0]   bus_in,
  output logic [31:0]   bus_out,
  output logic          bus_oe,
  output logic          tgt_rdy_n,
  output logic          tgt_rdy_oe,
  output logic          mem_req,
  output logic          mem_we,
  output logic [LW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_TURN, S_DATA, S_DONE} st_t;

  st_t           st, st_nx;
  logic          cyc_q, rd_q;
  logic [LW-1:0] idx_q;

  wire        fresh  = !cyc_n && cyc_q;
  wire [31:0] off    = bus_in - BASE;
  wire        hit    = (bus_in >= BASE) && (off < 32'(SIZE));
  wire        cmd_rd = bus_cmd == 4'b0110;
  wire        cmd_wr = bus_cmd == 4'b0111;
  wire        beat   = mem_req && mem_ready;

  assign mem_req    = (st == S_DATA) && !mst_rdy_n;
  assign tgt_rdy_n  = !beat;
  assign tgt_rdy_oe = (st == S_TURN) || (st == S_DATA) || (st == S_DONE);
  assign bus_oe     = (st == S_DATA) && rd_q;
  assign bus_out    = mem_rdata;
  assign mem_we     = !rd_q;
  assign mem_addr   = idx_q;
  assign mem_wdata  = bus_in;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (fresh) st_nx = S_ADDR;
      S_ADDR:  if (hit && (cmd_rd || cmd_wr)) st_nx = cmd_rd ? S_TURN : S_DATA;
               else st_nx = S_IDLE;
      S_TURN:  st_nx = S_DATA;
      S_DATA:  if (beat && cyc_n) st_nx = S_DONE;
      S_DONE:  st_nx = fresh ? S_ADDR : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cyc_q <= 1'b1;
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      st    <= st_nx;
      cyc_q <= cyc_n;
      if (st == S_ADDR) begin
        rd_q  <= cmd_rd;
        idx_q <= off[LW+1:2];
      end else if (beat) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_target_chk.sv
module burst_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mst_rdy_n,
  input logic        tgt_rdy_n,
  input logic        tgt_rdy_oe,
  input logic        bus_oe,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr_w
);

  assert_beat_both_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rdy_n |-> (!mst_rdy_n && tgt_rdy_oe));

  assert_dead_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(tgt_rdy_oe));

  assert_drive_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> tgt_rdy_oe);

  assert_release_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rdy_oe) |-> $past(tgt_rdy_n));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && mem_ready))
      |-> ((mem_addr_w == $past(mem_addr_w) + 32'd1) || (mem_addr_w == 32'd0)));

  assert_dir_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_we == $past(mem_we)));

endmodule

bind burst_target burst_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_rdy_n  (mst_rdy_n),
  .tgt_rdy_n  (tgt_rdy_n),
  .tgt_rdy_oe (tgt_rdy_oe),
  .bus_oe     (bus_oe),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr_w (32'(mem_addr))
);

// File: tb/burst_target_test.sv
`timescale 1ns/1ps
module burst_target_test;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int SIZE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_n = 1'b1, mst_rdy_n = 1'b1, mem_ready = 1'b1;
  logic [3:0] bus_cmd = 4'h0;
  logic [31:0] bus_in = 32'h0;
  logic [31:0] bus_out, mem_wdata, mem_rdata;
  logic bus_oe, tgt_rdy_n, tgt_rdy_oe, mem_req, mem_we;
  logic [3:0] mem_addr;
  logic [31:0] mem [16];
  logic [15:0] lfsr = 16'hACE1;

  int n_tests = 0, n_fail = 0;
  int m_st = 0, m_off = 0;
  bit m_fq = 1'b1, m_rd = 1'b0, m_beat = 1'b0, done = 1'b0;
  int rd_mode = 0;
  string tag_ctl = "R1";

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  burst_target uut (.clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .mst_rdy_n(mst_rdy_n),
    .bus_cmd(bus_cmd), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .tgt_rdy_n(tgt_rdy_n), .tgt_rdy_oe(tgt_rdy_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  function automatic void chk(bit ok, string tg, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
    end
  endfunction

  function automatic string tag_now();
    case (m_st)
      2: return "R5";
      3: return "R6";
      4: return "R10";
      default: return tag_ctl;
    endcase
  endfunction

  task automatic cycle();
    bit toe, req, beat, aoe, nrd;
    int nst, idx;
    mem_ready = (rd_mode == 0) ? 1'b1 : lfsr[3];
    #1;
    toe = m_st >= 2;
    req = (m_st == 3) && !mst_rdy_n;
    beat = req && mem_ready;
    aoe = (m_st == 3) && m_rd;
    idx = m_off / 4;
    chk(tgt_rdy_oe === toe, tag_now(), 32'(tgt_rdy_oe), 32'(toe));
    chk(tgt_rdy_n === !beat, tag_now(), 32'(tgt_rdy_n), 32'(!beat));
    chk(bus_oe === aoe, aoe ? "R9" : tag_now(), 32'(bus_oe), 32'(aoe));
    chk(mem_req === req, (m_st == 3) ? "R6" : tag_now(), 32'(mem_req), 32'(req));
    if (req) begin
      chk(mem_we === !m_rd, "R8", 32'(mem_we), 32'(!m_rd));
      chk(mem_addr === 4'(idx), "R7", 32'(mem_addr), 32'(idx));
      if (!m_rd) chk(mem_wdata === bus_in, "R8", mem_wdata, bus_in);
    end
    if (aoe) chk(bus_out === mem[idx], "R9", bus_out, mem[idx]);
    nst = m_st;
    nrd = m_rd;
    case (m_st)
      0, 4: nst = (!cyc_n && m_fq) ? 1 : 0;
      1: if ((bus_cmd == 4'b0110 || bus_cmd == 4'b0111) && bus_in >= BASE && bus_in < BASE + SIZE) begin
           nrd = bus_cmd == 4'b0110;
           nst = nrd ? 2 : 3;
         end else nst = 0;
      2: nst = 3;
      3: if (beat && cyc_n) nst = 4;
      default: nst = 0;
    endcase
    m_beat = beat;
    @(posedge clk);
    if (m_st == 1 && nst != 0) begin
      m_rd = nrd;
      m_off = int'(bus_in - BASE);
    end
    if (beat) begin
      if (!m_rd) mem[idx] = bus_in;
      m_off = (m_off + 4) % SIZE;
    end
    m_st = nst;
    m_fq = cyc_n;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                      input int imode, input int rmode, input string tg, input bit gap);
    int left = n;
    int guard = 0;
    tag_ctl = tg;
    rd_mode = rmode;
    cyc_n = 1'b0; mst_rdy_n = 1'b1; bus_cmd = 4'h7; bus_in = 32'hFFFF_0000;
    cycle();
    bus_cmd = cmd; bus_in = addr;
    cycle();
    bus_cmd = 4'h0;
    if (m_st == 0) begin
      mst_rdy_n = 1'b0; bus_in = 32'h1234_5678;
      cycle(); cycle();
      cyc_n = 1'b1;
      cycle();
    end else begin
      while (left > 0 && guard < 400) begin
        guard++;
        cyc_n = (left == 1);
        mst_rdy_n = (imode == 0) ? 1'b0 : lfsr[0];
        bus_in = (cmd == 4'b0111) ? {lfsr, 16'(guard)} : 32'hDEAD_0000;
        cycle();
        if (m_beat) left--;
      end
      chk(left == 0, tg, 32'(left), 32'h0);
    end
    cyc_n = 1'b1; mst_rdy_n = 1'b1; bus_in = 32'h0;
    if (gap) begin cycle(); cycle(); end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h5A00_0000 + 32'(i * 32'h0101);
    @(negedge clk);
    tag_ctl = "R1";
    for (int i = 0; i < 3; i++) cycle();
    rst_n = 1'b1;
    cycle();
    xact(4'b0111, BASE,          4, 0, 0, "R2",  1'b1);
    xact(4'b0110, BASE,          4, 0, 0, "R5",  1'b1);
    xact(4'b0110, BASE + 8,      6, 1, 1, "R6",  1'b1);
    xact(4'b0111, BASE + 4,      8, 1, 1, "R6",  1'b1);
    xact(4'b0110, BASE + 20,     1, 0, 1, "R10", 1'b1);
    xact(4'b0111, BASE + 60,     1, 1, 0, "R10", 1'b1);
    xact(4'b0010, BASE,          3, 0, 0, "R3",  1'b1);
    xact(4'b1111, BASE + 4,      3, 0, 0, "R3",  1'b1);
    xact(4'b0111, BASE - 4,      2, 0, 0, "R4",  1'b1);
    xact(4'b0110, BASE + SIZE,   2, 0, 0, "R4",  1'b1);
    xact(4'b0111, BASE + 56,     5, 0, 1, "R7",  1'b1);
    xact(4'b0110, BASE + 52,     6, 1, 0, "R7",  1'b1);
    xact(4'b0111, BASE + 12,     3, 0, 0, "R11", 1'b0);
    xact(4'b0110, BASE + 12,     3, 0, 0, "R11", 1'b0);
    xact(4'b0111, BASE + 32,     2, 1, 1, "R11", 1'b1);
    for (int k = 0; k < 4; k++)
      xact((k % 2 == 0) ? 4'b0110 : 4'b0111, BASE + 32'(4 * k), 40, 1, 1, "R6", 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule